// File: doc/BRIEF.md
# High-Speed Detection Handshake Controller (Device Side)

This block sits on the upstream port of a device. While the host holds the bus in single-ended zero (SE0), it decides whether to advertise high-speed capability. It watches a decoded SE0 indication, which it synchronises internally, and measures every interval by counting its own clock. It drives two things: a request that tells the transmitter to send Chirp K, and a termination select that chooses high-speed or full-speed terminations. The device always comes out of reset in full-speed mode.

There are two ways in. From full-speed operation, SE0 that is held continuously for a qualification time counts as a bus reset. From high-speed operation, SE0 that lasts long enough first makes the block fall back to full-speed terminations. After a settling interval it looks at the line again. If SE0 is still there, the event is a reset and the chirp goes ahead. If SE0 has gone, the event was a suspend, and the block stays idle at full speed without driving the line.

On both paths the chirp starts after a fixed, parameterised delay and lasts a parameterised length. Elaboration-time checks confirm that the chirp is long enough, that it starts inside the allowed window, and that it finishes before the deadline measured from the start of reset. A one-cycle pulse marks the end of the chirp, and a flag records which path led to it. An external detector recognises the host's reply chirps and reports them as an acknowledge; when that acknowledge arrives, the block switches to high-speed terminations.

Top module: `hs_chirp_ctrl`

## Requirements
- R1: After reset `chirp_k_en`, `hs_term_sel`, `hs_detect_done` and `entry_from_hs` are all 0.
- R2: In full-speed idle, once the synchronised SE0 has been high continuously for `T_QUAL` cycles and then for a further `T_CHIRP_DLY` cycles, `chirp_k_en` is 1 for exactly `T_CHIRP` consecutive cycles.
- R3: Any cycle without SE0 before qualification completes restarts the qualification count. A train of SE0 bursts, each shorter than `T_QUAL`, never leads to a chirp.
- R4: If SE0 ends during the delay before the chirp, the block returns to full-speed idle and `chirp_k_en` stays 0.
- R5: `hs_detect_done` is high for exactly one cycle: the first cycle after `chirp_k_en` falls.
- R6: After the chirp, `host_hs_ack` = 1 sets `hs_term_sel` to 1, and it stays 1 after SE0 ends. If SE0 ends before any acknowledge, the block returns to full-speed idle with `hs_term_sel` = 0.
- R7: In high-speed mode, SE0 that stays high for `T_HS_IDLE` cycles clears `hs_term_sel`. If SE0 is still present `T_SETTLE` cycles later, the chirp sequence of R2/R5 follows, using the same `T_CHIRP_DLY` delay.
- R8: If SE0 is gone when the settling interval ends, no chirp is driven and the block stays in full-speed idle with `hs_term_sel` = 0.
- R9: `entry_from_hs` is set when a chirp delay begins: 1 if the block came through the high-speed path (R7), 0 if it came through the full-speed path (R2). It holds that value until the next chirp delay begins.
- R10: `chirp_k_en` and `hs_term_sel` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all thresholds are counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_se0 | input | 1 | Decoded line state: 1 while both data lines are low |
| host_hs_ack | input | 1 | Host reply chirps recognised; selects high speed |
| chirp_k_en | output | 1 | Request to transmit Chirp K |
| hs_term_sel | output | 1 | 1 = high-speed terminations, 0 = full-speed |
| hs_detect_done | output | 1 | One-cycle pulse when the device chirp ends |
| entry_from_hs | output | 1 | 1 if the last handshake began in high-speed mode |

## Verification
The bench sends SE0 bursts one cycle shorter than qualification, separated by single-cycle gaps. A qualifier that did not restart on a break would add the bursts together and chirp on a line that was never held in reset. It removes SE0 partway through the pre-chirp delay, where a design without the abort would drive K onto a live bus. On the high-speed path it ends SE0 inside the settling window, so a design that treated every long SE0 as a reset would chirp out of a suspend. A cycle-accurate model checks the chirp length and the single-cycle done pulse on every clock, so an off-by-one in either shows up as a mismatch.

// File: rtl/hs_chirp_pkg.sv
package hs_chirp_pkg;

   typedef enum logic [2:0] {
      ST_FS_IDLE = 3'd0,
      ST_DELAY   = 3'd1,
      ST_CHIRP   = 3'd2,
      ST_WAIT    = 3'd3,
      ST_HS_RUN  = 3'd4,
      ST_REVERT  = 3'd5
   } hsc_state_e;

   function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/hs_chirp_sync.sv
module hs_chirp_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else if (STAGES == 1) begin : g_single
         logic r_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r_q <= 1'b0;
            else        r_q <= d;
         end
         assign q = r_q;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], d};
         end
         assign q = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/hs_chirp_satcnt.sv
module hs_chirp_satcnt #(
   parameter int unsigned LIMIT = 15,
   localparam int unsigned W    = $clog2(LIMIT + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   output logic [W-1:0] count
);
   localparam logic [W-1:0] TOP = W'(LIMIT);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("hs_chirp_satcnt: LIMIT must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            count <= '0;
      else if (clr)          count <= '0;
      else if (count != TOP) count <= count + 1'b1;
   end
endmodule

// File: rtl/hs_chirp_ctrl.sv
module hs_chirp_ctrl
   import hs_chirp_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned T_QUAL      = 150,
   parameter int unsigned T_HS_IDLE   = 180000,
   parameter int unsigned T_SETTLE    = 6000,
   parameter int unsigned T_CHIRP_DLY = 6000,
   parameter int unsigned T_CHIRP     = 120000,
   parameter int unsigned MIN_CHIRP   = 60000,
   parameter int unsigned START_MIN   = 150,
   parameter int unsigned START_MAX   = 360000,
   parameter int unsigned DEADLINE    = 420000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_se0,
   input  logic host_hs_ack,
   output logic chirp_k_en,
   output logic hs_term_sel,
   output logic hs_detect_done,
   output logic entry_from_hs
);
   localparam int unsigned RL_LIM = max_of(T_QUAL, T_HS_IDLE);
   localparam int unsigned DW_LIM = max_of(max_of(T_CHIRP_DLY, T_CHIRP), T_SETTLE);
   localparam int unsigned RL_W   = $clog2(RL_LIM + 1);
   localparam int unsigned DW_W   = $clog2(DW_LIM + 1);
   localparam logic [RL_W-1:0] QUAL_C   = RL_W'(T_QUAL);
   localparam logic [RL_W-1:0] HSIDLE_C = RL_W'(T_HS_IDLE);
   localparam logic [DW_W-1:0] DLY_END  = DW_W'(T_CHIRP_DLY - 1);
   localparam logic [DW_W-1:0] CHP_END  = DW_W'(T_CHIRP - 1);
   localparam logic [DW_W-1:0] STL_END  = DW_W'(T_SETTLE - 1);

   // timing budget checked at elaboration
   generate
      if (T_QUAL < 1 || T_HS_IDLE < 1 || T_SETTLE < 1 || T_CHIRP_DLY < 1 || T_CHIRP < 1) begin : g_zero
         $error("hs_chirp_ctrl: every interval must be at least one cycle");
      end
      if (T_CHIRP < MIN_CHIRP) begin : g_short
         $error("hs_chirp_ctrl: chirp shorter than the minimum length");
      end
      if (T_QUAL + T_CHIRP_DLY < START_MIN || T_QUAL + T_CHIRP_DLY > START_MAX) begin : g_window
         $error("hs_chirp_ctrl: chirp start outside the full-speed window");
      end
      if (T_QUAL + T_CHIRP_DLY + T_CHIRP > DEADLINE) begin : g_fs_late
         $error("hs_chirp_ctrl: full-speed path misses the deadline");
      end
      if (T_HS_IDLE + T_SETTLE + T_CHIRP_DLY + T_CHIRP > DEADLINE) begin : g_hs_late
         $error("hs_chirp_ctrl: high-speed path misses the deadline");
      end
   endgenerate

   logic            se0_s;
   logic [RL_W-1:0] run_len;
   logic [DW_W-1:0] dwell;
   hsc_state_e      state_q, state_d;
   logic            changing;

   hs_chirp_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .d(line_se0), .q(se0_s)
   );

   assign changing = (state_d != state_q);

   // continuous SE0 length since last break or state change
   hs_chirp_satcnt #(.LIMIT(RL_LIM)) i_run_len (
      .clk(clk), .rst_n(rst_n), .clr(changing || !se0_s), .count(run_len)
   );

   // cycles spent in the current state
   hs_chirp_satcnt #(.LIMIT(DW_LIM)) i_dwell (
      .clk(clk), .rst_n(rst_n), .clr(changing), .count(dwell)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_FS_IDLE: if (run_len >= QUAL_C) state_d = ST_DELAY;
         ST_DELAY: begin
            if (!se0_s)                state_d = ST_FS_IDLE;
            else if (dwell == DLY_END) state_d = ST_CHIRP;
         end
         ST_CHIRP:   if (dwell == CHP_END) state_d = ST_WAIT;
         ST_WAIT: begin
            if (host_hs_ack)  state_d = ST_HS_RUN;
            else if (!se0_s)  state_d = ST_FS_IDLE;
         end
         ST_HS_RUN:  if (run_len >= HSIDLE_C) state_d = ST_REVERT;
         ST_REVERT:  if (dwell == STL_END) state_d = se0_s ? ST_DELAY : ST_FS_IDLE;
         default:    state_d = ST_FS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q        <= ST_FS_IDLE;
         hs_detect_done <= 1'b0;
         entry_from_hs  <= 1'b0;
      end else begin
         state_q        <= state_d;
         hs_detect_done <= (state_q == ST_CHIRP) && (state_d == ST_WAIT);
         if (state_d == ST_DELAY && state_q != ST_DELAY)
            entry_from_hs <= (state_q == ST_REVERT);
      end
   end

   assign chirp_k_en  = (state_q == ST_CHIRP);
   assign hs_term_sel = (state_q == ST_HS_RUN);

   AST_NO_DUAL_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(chirp_k_en && hs_term_sel)); // R10
   AST_CHIRP_AFTER_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chirp_k_en) |-> $past(state_q == ST_DELAY && se0_s)); // R2
   AST_ABORT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DELAY && !se0_s) |=> !chirp_k_en); // R4
   AST_DONE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      hs_detect_done |=> !hs_detect_done); // R5
   AST_DONE_FOLLOWS_CHIRP: assert property (@(posedge clk) disable iff (!rst_n)
      hs_detect_done |-> ($past(chirp_k_en) && !chirp_k_en)); // R5
   AST_HS_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_term_sel) |-> $past(host_hs_ack)); // R6
   AST_HS_FALLS_BACK: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_term_sel && run_len >= HSIDLE_C) |=> !hs_term_sel); // R7
endmodule

// File: tb/test_hs_chirp_ctrl.sv
module test_hs_chirp_ctrl;
   localparam int QUAL = 5, HSI = 30, STL = 4, DLY = 6, CHP = 12;
   localparam int RLMAX = 30, DWMAX = 12;

   logic clk = 1'b0, rst_n = 1'b0, se0 = 1'b0, ack = 1'b0;
   logic chirp, hsterm, done, ent;
   int n_cmp = 0, n_bad = 0, cyc = 0;
   int chirp_cnt = 0, done_cnt = 0;

   always #5 clk = ~clk;

   hs_chirp_ctrl #(.SYNC_STAGES(2), .T_QUAL(QUAL), .T_HS_IDLE(HSI), .T_SETTLE(STL),
      .T_CHIRP_DLY(DLY), .T_CHIRP(CHP), .MIN_CHIRP(10), .START_MIN(3),
      .START_MAX(60), .DEADLINE(70)) i_hs_chirp_ctrl (
      .clk(clk), .rst_n(rst_n), .line_se0(se0), .host_hs_ack(ack),
      .chirp_k_en(chirp), .hs_term_sel(hsterm), .hs_detect_done(done),
      .entry_from_hs(ent));

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // behavioural reference: 0 idle,1 delay,2 chirp,3 wait,4 hs,5 revert
   int m_st = 0, m_rl = 0, m_dw = 0, m_ent = 0, m_done = 0;
   bit pipe[$] = '{1'b0, 1'b0};
   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_rl = 0; m_dw = 0; m_ent = 0; m_done = 0;
         pipe = '{1'b0, 1'b0};
      end else begin
         bit s;
         int ns;
         s = pipe[0];
         ns = m_st;
         case (m_st)
            0: if (m_rl >= QUAL) ns = 1;
            1: if (!s) ns = 0; else if (m_dw == DLY - 1) ns = 2;
            2: if (m_dw == CHP - 1) ns = 3;
            3: if (ack) ns = 4; else if (!s) ns = 0;
            4: if (m_rl >= HSI) ns = 5;
            5: if (m_dw == STL - 1) ns = s ? 1 : 0;
            default: ns = 0;
         endcase
         m_done = (m_st == 2 && ns == 3) ? 1 : 0;
         if (ns == 1 && m_st != 1) m_ent = (m_st == 5) ? 1 : 0;
         m_rl = (ns != m_st || !s) ? 0 : ((m_rl + 1 > RLMAX) ? RLMAX : m_rl + 1);
         m_dw = (ns != m_st) ? 0 : ((m_dw + 1 > DWMAX) ? DWMAX : m_dw + 1);
         m_st = ns;
         void'(pipe.pop_front());
         pipe.push_back(se0);
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R2", "chirp_k_en", int'(chirp), (m_st == 2) ? 1 : 0);
         chk("R6", "hs_term_sel", int'(hsterm), (m_st == 4) ? 1 : 0);
         chk("R5", "hs_detect_done", int'(done), m_done);
         chk("R9", "entry_from_hs", int'(ent), m_ent);
         chk("R10", "chirp_and_hs_term", int'(chirp && hsterm), 0);
         chirp_cnt += int'(chirp);
         done_cnt  += int'(done);
      end
   end

   task automatic step(input int n);
      repeat (n) begin @(posedge clk); #2; end
   endtask

   task automatic clear_counts();
      @(negedge clk); chirp_cnt = 0; done_cnt = 0;
   endtask

   task automatic wait_done();
      while (done_cnt == 0) step(1);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_bad++;
         $display("FAIL watchdog expired actual %0d expected below 20000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(2);
      @(negedge clk);
      chk("R1", "reset chirp", int'(chirp), 0);
      chk("R1", "reset hs_term", int'(hsterm), 0);
      chk("R1", "reset done", int'(done), 0);
      chk("R1", "reset entry", int'(ent), 0);
      step(1);

      // R3: short bursts separated by one-cycle breaks
      clear_counts(); step(1);
      for (int i = 0; i < 5; i++) begin
         se0 = 1'b1; step(QUAL - 1);
         se0 = 1'b0; step(1);
      end
      step(20);
      chk("R3", "chirp cycles after short bursts", chirp_cnt, 0);

      // R2/R5/R9: full-speed reset, no host answer
      clear_counts(); step(1);
      se0 = 1'b1; step(40);
      chk("R2", "chirp length", chirp_cnt, CHP);
      chk("R5", "done pulses", done_cnt, 1);
      chk("R9", "entry after fs path", int'(ent), 0);
      se0 = 1'b0; step(10);
      chk("R6", "no ack stays fs", int'(hsterm), 0);

      // R4: abort during chirp delay
      clear_counts(); step(1);
      se0 = 1'b1; step(QUAL + 4);
      se0 = 1'b0; step(30);
      chk("R4", "chirp cycles after abort", chirp_cnt, 0);

      // R6: host acknowledges, switch to high speed
      clear_counts(); step(1);
      se0 = 1'b1; wait_done();
      ack = 1'b1; step(1);
      ack = 1'b0; step(2);
      chk("R6", "hs_term after ack", int'(hsterm), 1);
      se0 = 1'b0; step(20);
      chk("R6", "hs_term after se0 ends", int'(hsterm), 1);

      // R7/R9: reset seen while at high speed
      clear_counts(); step(1);
      se0 = 1'b1; step(70);
      chk("R7", "chirp length on hs path", chirp_cnt, CHP);
      chk("R7", "hs_term dropped", int'(hsterm), 0);
      chk("R9", "entry after hs path", int'(ent), 1);
      ack = 1'b1; step(1);
      ack = 1'b0; se0 = 1'b0; step(10);
      chk("R6", "back at high speed", int'(hsterm), 1);

      // R8: long SE0 at high speed that ends inside the settling window
      clear_counts(); step(1);
      se0 = 1'b1; step(HSI + 3);
      se0 = 1'b0; step(30);
      chk("R8", "hs_term after suspend", int'(hsterm), 0);
      chk("R8", "chirp cycles after suspend", chirp_cnt, 0);
      chk("R9", "entry unchanged", int'(ent), 1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule